// File: doc/BRIEF.md
# Aligned Base-Address I/O Decoder

This block places one logical device in a 16-bit I/O space. A configuration port writes a base address register, one byte at a time, plus a control register that holds an enable bit. Every I/O address presented to the block is compared with that base. The block returns a chip-select and the offset of the addressed register inside the device's window.

The window size is a parameter and may be 2, 4, 8 or 16 bytes. Base bits below the window size cannot be written and always read as zero, so the base is always aligned to the window. A second parameter marks the device as legacy-class. A legacy-class base is held below 0800h because its five top bits are forced to zero. A device without that mark may sit anywhere in the 16-bit space.

The chip-select and the offset are combinational from the address. A configuration write takes effect on the next clock edge.

Top module: `io_base_decoder`

## Requirements
- R1: After reset, the base register and the enable bit are zero, every configuration read returns 00h, and io_cs is low for every address.
- R2: io_offset always equals the lowest OFF_W = log2(RANGE_BYTES) bits of io_addr, whatever the state of io_cs.
- R3: io_cs is high exactly when the enable bit is set, the base is non-zero, and io_addr with its low OFF_W bits cleared equals the base. All 16 address bits take part in the compare.
- R4: Writing index 0 loads base bits [7:0]. Bits below OFF_W are not written and read as zero.
- R5: When LEGACY=1, base bits [15:11] are not written and read as zero. io_cs is then never high for an address at or above 0800h.
- R6: When LEGACY=0, every base bit from OFF_W up to bit 15 is writable through index 1 (bits [15:8]) and index 0.
- R7: Clearing the enable bit forces io_cs low for every address, and the base keeps its value.
- R8: A base of 0000h keeps io_cs low for every address, even when the enable bit is set.
- R9: Index 2 holds the enable bit in data bit 0, and its bits [7:1] read as zero. Writes to index 3 change nothing, and reads of index 3 return 00h.
- R10: A write with cfg_we high is visible on cfg_rdata and on io_cs from the next rising clock edge. When cfg_we is low, the registers do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Configuration register index: 0 base low byte, 1 base high byte, 2 control, 3 unused |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx, combinational |
| io_addr | input | 16 | I/O address to decode |
| io_cs | output | 1 | Device selected |
| io_offset | output | OFF_W | Register offset within the window |

## Verification
A wrong bit in the stored base, or a forced bit that is wrongly stored, shows up on cfg_rdata in the cycle right after the write. It also moves the window that io_cs marks, so address sweeps around the expected base catch it with no delay. A stuck or ignored enable bit, or a missing zero-base guard, shows at once as io_cs high where the model expects it low. The bench sweeps addresses near each base and across the whole space, on a legacy instance and on a full-range instance.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    localparam int IO_AW = 16;

    typedef enum logic [1:0] {
        CFG_BASE_LO = 2'd0,
        CFG_BASE_HI = 2'd1,
        CFG_CTRL    = 2'd2,
        CFG_NONE    = 2'd3
    } cfg_idx_e;

    typedef struct packed {
        logic [IO_AW-1:0] base;
        logic             en;
    } dec_state_t;

endpackage

// File: rtl/io_dec_regs.sv
module io_dec_regs
    import io_dec_pkg::*;
#(
    parameter logic [IO_AW-1:0] WR_MASK = 16'hFFF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_idx,
    input  logic [7:0]       cfg_wdata,
    output logic [IO_AW-1:0] base_q,
    output logic             en_q
);

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_idx_e'(cfg_idx))
                CFG_BASE_LO: st_d.base[7:0]  = cfg_wdata & WR_MASK[7:0];
                CFG_BASE_HI: st_d.base[15:8] = cfg_wdata & WR_MASK[15:8];
                CFG_CTRL:    st_d.en         = cfg_wdata[0];
                default:     st_d            = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q = st_q.base;
    assign en_q   = st_q.en;

    // R4
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == 2'd0) |=> (base_q[7:0] == ($past(cfg_wdata) & WR_MASK[7:0])));

    // R9
    unused_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == 2'd3) |=> ($stable(base_q) && $stable(en_q)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(base_q) && $stable(en_q)));

    // R5
    forced_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q & ~WR_MASK) == '0);

endmodule

// File: rtl/io_dec_match.sv
module io_dec_match
    import io_dec_pkg::*;
#(
    parameter int               OFF_W      = 3,
    parameter logic [IO_AW-1:0] ALIGN_MASK = 16'hFFF8
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_AW-1:0] base,
    input  logic             en,
    output logic             cs,
    output logic [OFF_W-1:0] offset
);

    logic hit;

    always_comb begin
        hit    = ((io_addr & ALIGN_MASK) == base);
        cs     = en && (|base) && hit;
        offset = io_addr[OFF_W-1:0];
    end

endmodule

// File: rtl/io_dec_rdmux.sv
module io_dec_rdmux
    import io_dec_pkg::*;
(
    input  logic [1:0]       cfg_idx,
    input  logic [IO_AW-1:0] base,
    input  logic             en,
    output logic [7:0]       rdata
);

    always_comb begin
        case (cfg_idx_e'(cfg_idx))
            CFG_BASE_LO: rdata = base[7:0];
            CFG_BASE_HI: rdata = base[15:8];
            CFG_CTRL:    rdata = {7'd0, en};
            default:     rdata = 8'd0;
        endcase
    end

endmodule

// File: rtl/io_base_decoder.sv
module io_base_decoder
    import io_dec_pkg::*;
#(
    parameter int  RANGE_BYTES = 8,
    parameter bit  LEGACY      = 1'b0,
    localparam int OFF_W       = $clog2(RANGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_idx,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [15:0]      io_addr,
    output logic             io_cs,
    output logic [OFF_W-1:0] io_offset
);

    localparam logic [IO_AW-1:0] ALIGN_MASK = ~((16'(1) << OFF_W) - 16'(1));
    localparam logic [IO_AW-1:0] LEG_MASK   = LEGACY ? 16'h07FF : 16'hFFFF;
    localparam logic [IO_AW-1:0] WR_MASK    = ALIGN_MASK & LEG_MASK;

    logic [IO_AW-1:0] base_q;
    logic             en_q;

    io_dec_regs #(.WR_MASK(WR_MASK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_wdata(cfg_wdata),
        .base_q   (base_q),
        .en_q     (en_q)
    );

    io_dec_match #(.OFF_W(OFF_W), .ALIGN_MASK(ALIGN_MASK)) u_match (
        .io_addr(io_addr),
        .base   (base_q),
        .en     (en_q),
        .cs     (io_cs),
        .offset (io_offset)
    );

    io_dec_rdmux u_rdmux (
        .cfg_idx(cfg_idx),
        .base   (base_q),
        .en     (en_q),
        .rdata  (cfg_rdata)
    );

    // R7
    cs_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_cs |-> en_q);

    // R8
    cs_zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_cs |-> (base_q != '0));

    generate
        if (LEGACY) begin : g_legacy
            // R5
            legacy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                io_cs |-> (io_addr[15:11] == 5'd0));
        end
    endgenerate

endmodule

// File: tb/test_io_base_decoder.sv
`timescale 1ns/1ps
module test_io_base_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [15:0] io_addr = 16'd0;

    logic [7:0]  rd_a, rd_b;
    logic        cs_a, cs_b;
    logic [2:0]  off_a;
    logic [1:0]  off_b;

    int checks = 0;
    int errors = 0;

    logic [7:0] w_lo = 8'd0, w_hi = 8'd0;
    logic       w_en = 1'b0;

    always #2 clk = ~clk;

    // full-range device, 8-byte window
    io_base_decoder #(.RANGE_BYTES(8), .LEGACY(1'b0)) i_io_base_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .io_addr(io_addr),
        .io_cs(cs_a), .io_offset(off_a)
    );

    // legacy-class device, 4-byte window
    io_base_decoder #(.RANGE_BYTES(4), .LEGACY(1'b1)) i_io_base_decoder_leg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .io_addr(io_addr),
        .io_cs(cs_b), .io_offset(off_b)
    );

    function automatic logic [15:0] base_a();
        return {w_hi, w_lo} & 16'hFFF8;
    endfunction

    function automatic logic [15:0] base_b();
        return {w_hi, w_lo} & 16'h07FC;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (idx)
            2'd0: w_lo = d;
            2'd1: w_hi = d;
            2'd2: w_en = d[0];
            default: ;
        endcase
    endtask

    task automatic check_reads(input string tag);
        logic [15:0] ba, bb;
        ba = base_a(); bb = base_b();
        cfg_idx = 2'd0; #0.5;
        chk(tag, "A lo", rd_a, ba[7:0]);
        chk(tag, "B lo", rd_b, bb[7:0]);
        cfg_idx = 2'd1; #0.5;
        chk(tag, "A hi", rd_a, ba[15:8]);
        chk(tag, "B hi", rd_b, bb[15:8]);
        cfg_idx = 2'd2; #0.5;
        chk(tag, "A ctrl", rd_a, {7'd0, w_en});
        chk(tag, "B ctrl", rd_b, {7'd0, w_en});
        cfg_idx = 2'd3; #0.5;
        chk(tag, "A idx3", rd_a, 0);
        chk(tag, "B idx3", rd_b, 0);
    endtask

    task automatic check_addr(input string tag, input logic [15:0] a);
        logic ea, eb;
        io_addr = a; #0.5;
        ea = w_en && (base_a() != 16'd0) && ((a & 16'hFFF8) == base_a());
        eb = w_en && (base_b() != 16'd0) && ((a & 16'hFFFC) == base_b());
        chk(tag, "A cs", cs_a, ea);
        chk(tag, "B cs", cs_b, eb);
        chk("R2", "A offset", off_a, a[2:0]);
        chk("R2", "B offset", off_b, a[1:0]);
    endtask

    task automatic sweep(input string tag);
        for (int k = -20; k <= 20; k++) check_addr(tag, base_a() + 16'(k));
        for (int k = -20; k <= 20; k++) check_addr(tag, base_b() + 16'(k));
        for (int i = 0; i < 65536; i += 251) check_addr(tag, 16'(i));
        check_addr(tag, 16'hFFFF);
        check_addr(tag, 16'h07FF);
        check_addr(tag, 16'h0800);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_reads("R1");
        sweep("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R6 / R4 / R5: mixed bytes, low bits and legacy bits forced
        wr(2'd0, 8'h3F); wr(2'd1, 8'h12); wr(2'd2, 8'h01);
        check_reads("R4");
        sweep("R3");

        // R6 / R5: all ones
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        check_reads("R6");
        check_reads("R5");
        sweep("R5");

        // R10: single write visible on the next edge
        wr(2'd0, 8'h08); wr(2'd1, 8'h00);
        check_reads("R10");
        sweep("R3");

        // R9: index 3 write ignored, ctrl upper bits read zero
        wr(2'd3, 8'hFF);
        check_reads("R9");
        sweep("R9");
        wr(2'd2, 8'hFE);
        check_reads("R9");

        // R7: disabled device never selects
        wr(2'd0, 8'hF4); wr(2'd1, 8'h03);
        check_reads("R7");
        sweep("R7");
        wr(2'd2, 8'h01);
        sweep("R3");

        // R8: zero base with enable set
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        check_reads("R8");
        sweep("R8");

        // R5: legacy upper bits only
        wr(2'd1, 8'hF8); wr(2'd0, 8'h04);
        check_reads("R5");
        sweep("R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule